// File: doc/BRIEF.md
# Calendar Timekeeping Core with Deferred Register Commit

This block keeps wall-clock time (hours, minutes, seconds) and a calendar date (day, month, year, leap flag). Each one-cycle pulse on `tick` marks one elapsed second. Software sees three words on a small register port: a control word carrying two busy flags, a packed time-of-day word and a packed date word. Reads are combinational and return the live counter state.

Writes to the time or date word do not take effect at once. The written value is staged, and that word's busy flag rises. The value is committed only on the second `tick` after the write, which models the hand-off into a slow timekeeping domain. The busy flag falls in the same cycle that the new value appears. Software is expected to poll the control word until both flags are clear, and to write the time word before the date word. The year field counts years from 1970 in six bits, so the span is 1970 to 2033.

Top module: `cal_core`

## Requirements
- R1: After reset the control word reads 0, the time word reads 0 (00:00:00) and the date word reads 0x00000101 (day 1, month 1, year offset 0, leap 0).
- R2: Address map on `bus_addr`: 0 is control, 1 is time, 2 is date, and 3 reads 0. Time packing: seconds in [5:0], minutes in [13:8], hours in [20:16]. Date packing: day in [4:0], month (1 to 12) in [11:8], year offset from 1970 in [21:16], leap flag in bit 22. Control packing: time busy in bit 8, date busy in bit 7.
- R3: A write to the time or date word while that word's busy flag is clear sets the flag in the next cycle.
- R4: A staged value is loaded on the second `tick` after its write. The busy flag clears at that same clock edge. Earlier ticks keep advancing the old count.
- R5: A write to a word whose busy flag is set is ignored, and the earlier staged value is the one committed. Writes to the control word or to address 3 have no effect.
- R6: On a tick, seconds at 59 roll to 0 and carry into minutes. Minutes at 59 roll to 0 and carry into hours.
- R7: Hours at 23 with minutes and seconds at 59 roll the time to 00:00:00 and advance the date by one day.
- R8: The day rolls to 1 and the month advances after the last day of the month: 30 days in months 4, 6, 9 and 11; 31 in the other months; in month 2, 29 days when the stored leap flag is 1 and 28 when it is 0.
- R9: After day 31 of month 12 the date becomes day 1 of month 1 of the next year offset. Offset 63 wraps to 0. The leap flag is recomputed as 1 exactly when the new offset modulo 4 equals 2.
- R10: Bits outside the defined fields read 0, and the written values keep only the defined field bits.
- R11: On the tick that commits a staged value, that word loads the value instead of counting. A day carry arriving on the tick that commits the date word is dropped.
- R12: The time word changes only at a clock edge where `tick` is high. The date word changes only on a day carry or a date commit. A read therefore never sees a mix of old and new fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per elapsed second |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 2 | Word select for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |

## Verification
The bench goes after the month-end boundaries: February with and without the leap flag, a 30-day month, a 31-day month, and the December-to-January step at both an ordinary year and the wrapping year 63. A design with a wrong month-length table or a miscomputed leap flag would land on the wrong day or carry the wrong leap bit into the new year. It also times the commit exactly: it checks that the old count still runs after one tick, and that value and busy flag change together after the second. An off-by-one in the tick counter would show the staged value one second early or late. A write issued while busy must not replace the staged value, and a day carry that coincides with a date commit must not be added on top of the new date. A design that let either through would read a different time or a date one day ahead.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int WORD_W   = 32;
  localparam int SEC_W    = 6;
  localparam int MIN_W    = 6;
  localparam int HR_W     = 5;
  localparam int DAY_W    = 5;
  localparam int MON_W    = 4;
  localparam int YR_W     = 6;

  localparam int SEC_LSB  = 0;
  localparam int MIN_LSB  = 8;
  localparam int HR_LSB   = 16;
  localparam int DAY_LSB  = 0;
  localparam int MON_LSB  = 8;
  localparam int YR_LSB   = 16;
  localparam int LEAP_BIT = 22;

  localparam int BUSY_TIME_BIT = 8;
  localparam int BUSY_DATE_BIT = 7;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TIME = 2'd1;
  localparam logic [1:0] ADDR_DATE = 2'd2;

  typedef struct packed {
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] min;
    logic [SEC_W-1:0] sec;
  } hms_t;

  typedef struct packed {
    logic             leap;
    logic [YR_W-1:0]  yr;
    logic [MON_W-1:0] mon;
    logic [DAY_W-1:0] day;
  } ymd_t;

  function automatic hms_t hms_from_word(logic [WORD_W-1:0] w);
    hms_t t;
    t.sec = w[SEC_LSB +: SEC_W];
    t.min = w[MIN_LSB +: MIN_W];
    t.hr  = w[HR_LSB  +: HR_W];
    return t;
  endfunction

  function automatic logic [WORD_W-1:0] hms_to_word(hms_t t);
    logic [WORD_W-1:0] w;
    w = '0;
    w[SEC_LSB +: SEC_W] = t.sec;
    w[MIN_LSB +: MIN_W] = t.min;
    w[HR_LSB  +: HR_W]  = t.hr;
    return w;
  endfunction

  function automatic ymd_t ymd_from_word(logic [WORD_W-1:0] w);
    ymd_t d;
    d.day  = w[DAY_LSB +: DAY_W];
    d.mon  = w[MON_LSB +: MON_W];
    d.yr   = w[YR_LSB  +: YR_W];
    d.leap = w[LEAP_BIT];
    return d;
  endfunction

  function automatic logic [WORD_W-1:0] ymd_to_word(ymd_t d);
    logic [WORD_W-1:0] w;
    w = '0;
    w[DAY_LSB +: DAY_W] = d.day;
    w[MON_LSB +: MON_W] = d.mon;
    w[YR_LSB  +: YR_W]  = d.yr;
    w[LEAP_BIT]         = d.leap;
    return w;
  endfunction

  // last day of a month; February depends on the stored leap flag
  function automatic logic [DAY_W-1:0] month_last_day(logic [MON_W-1:0] mon,
                                                       logic leap);
    logic [DAY_W-1:0] n;
    case (mon)
      4'd4, 4'd6, 4'd9, 4'd11: n = DAY_W'(30);
      4'd2:                    n = leap ? DAY_W'(29) : DAY_W'(28);
      default:                 n = DAY_W'(31);
    endcase
    return n;
  endfunction

  // offsets from 1970: a leap year sits at offset = 2 mod 4 in 1970..2033
  function automatic logic leap_of_offset(logic [YR_W-1:0] yr);
    return (yr[1:0] == 2'd2);
  endfunction

endpackage

// File: rtl/cal_commit.sv
module cal_commit #(
  parameter int W     = 17,
  parameter int TICKS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_req,
  input  logic [W-1:0] wr_val,
  output logic         busy,
  output logic         commit,
  output logic [W-1:0] staged
);

  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] seen;

  assign commit = busy && tick && (seen == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      seen   <= '0;
      staged <= '0;
    end else if (!busy) begin
      if (wr_req) begin
        busy   <= 1'b1;
        seen   <= '0;
        staged <= wr_val;
      end
    end else if (commit) begin
      busy <= 1'b0;
      seen <= '0;
    end else if (tick) begin
      seen <= seen + CW'(1);
    end
  end

endmodule

// File: rtl/cal_hms.sv
module cal_hms
  import cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic load,
  input  hms_t load_val,
  output hms_t cur,
  output logic day_carry
);

  logic wrap_s, wrap_m, wrap_h;

  assign wrap_s = (cur.sec >= SEC_W'(59));
  assign wrap_m = (cur.min >= MIN_W'(59));
  assign wrap_h = (cur.hr  >= HR_W'(23));

  assign day_carry = tick && !load && wrap_s && wrap_m && wrap_h;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (load) begin
      cur <= load_val;
    end else if (tick) begin
      cur.sec <= wrap_s ? '0 : cur.sec + SEC_W'(1);
      if (wrap_s) begin
        cur.min <= wrap_m ? '0 : cur.min + MIN_W'(1);
        if (wrap_m)
          cur.hr <= wrap_h ? '0 : cur.hr + HR_W'(1);
      end
    end
  end

endmodule

// File: rtl/cal_ymd.sv
module cal_ymd
  import cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  input  logic load,
  input  ymd_t load_val,
  output ymd_t cur
);

  logic            month_end, year_end;
  logic [YR_W-1:0] next_yr;

  assign month_end = (cur.day >= month_last_day(cur.mon, cur.leap));
  assign year_end  = month_end && (cur.mon >= MON_W'(12));
  assign next_yr   = cur.yr + YR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur.day  <= DAY_W'(1);
      cur.mon  <= MON_W'(1);
      cur.yr   <= '0;
      cur.leap <= 1'b0;
    end else if (load) begin
      cur <= load_val;
    end else if (advance) begin
      if (!month_end) begin
        cur.day <= cur.day + DAY_W'(1);
      end else if (!year_end) begin
        cur.day <= DAY_W'(1);
        cur.mon <= cur.mon + MON_W'(1);
      end else begin
        cur.day  <= DAY_W'(1);
        cur.mon  <= MON_W'(1);
        cur.yr   <= next_yr;
        cur.leap <= leap_of_offset(next_yr);
      end
    end
  end

endmodule

// File: rtl/cal_core.sv
module cal_core
  import cal_pkg::*;
#(
  parameter int COMMIT_TICKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);

  localparam int HMS_BITS = $bits(hms_t);
  localparam int YMD_BITS = $bits(ymd_t);

  logic wr_time, wr_date;
  logic busy_time, busy_date;
  logic time_commit, date_commit;
  logic day_carry;
  logic [HMS_BITS-1:0] time_stage;
  logic [YMD_BITS-1:0] date_stage;
  hms_t cur_time;
  ymd_t cur_date;
  logic [31:0] time_word, date_word, ctrl_word;

  assign wr_time = bus_wr && (bus_addr == ADDR_TIME);
  assign wr_date = bus_wr && (bus_addr == ADDR_DATE);

  cal_commit #(.W(HMS_BITS), .TICKS(COMMIT_TICKS)) u_time_commit (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .wr_req (wr_time),
    .wr_val (HMS_BITS'(hms_from_word(bus_wdata))),
    .busy   (busy_time),
    .commit (time_commit),
    .staged (time_stage)
  );

  cal_commit #(.W(YMD_BITS), .TICKS(COMMIT_TICKS)) u_date_commit (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .wr_req (wr_date),
    .wr_val (YMD_BITS'(ymd_from_word(bus_wdata))),
    .busy   (busy_date),
    .commit (date_commit),
    .staged (date_stage)
  );

  cal_hms u_hms (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load      (time_commit),
    .load_val  (hms_t'(time_stage)),
    .cur       (cur_time),
    .day_carry (day_carry)
  );

  cal_ymd u_ymd (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (day_carry),
    .load     (date_commit),
    .load_val (ymd_t'(date_stage)),
    .cur      (cur_date)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[BUSY_TIME_BIT] = busy_time;
    ctrl_word[BUSY_DATE_BIT] = busy_date;
  end

  assign time_word = hms_to_word(cur_time);
  assign date_word = ymd_to_word(cur_date);

  always_comb begin
    case (bus_addr)
      ADDR_CTRL: bus_rdata = ctrl_word;
      ADDR_TIME: bus_rdata = time_word;
      ADDR_DATE: bus_rdata = date_word;
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/cal_core_chk.sv
module cal_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic        busy_time,
  input logic        busy_date,
  input logic        time_commit,
  input logic        date_commit,
  input logic        day_carry,
  input logic [31:0] time_word,
  input logic [31:0] date_word
);

  // R3
  time_busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && !busy_time) |=> busy_time);

  // R3
  date_busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && !busy_date) |=> busy_date);

  // R4
  time_busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_time) |-> $past(time_commit));

  // R5
  time_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_time && !time_commit) |=> busy_time);

  // R6
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !time_commit && time_word[5:0] == 6'd59) |=> time_word[5:0] == 6'd0);

  // R11
  commit_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (time_commit || date_commit) |-> tick);

  // R12
  time_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(time_word));

  // R12
  date_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(day_carry || date_commit) |=> $stable(date_word));

endmodule

bind cal_core cal_core_chk u_cal_core_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .busy_time   (busy_time),
  .busy_date   (busy_date),
  .time_commit (time_commit),
  .date_commit (date_commit),
  .day_carry   (day_carry),
  .time_word   (time_word),
  .date_word   (date_word)
);

// File: tb/test_cal_core.sv
module test_cal_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [1:0]  addr;
    logic [31:0] val;
    string       tag;
  } exp_item_t;

  exp_item_t sb_q[$];

  always #10 clk = ~clk;

  cal_core i_cal_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  function automatic logic [31:0] tw(int h, int m, int s);
    return 32'(h * 65536 + m * 256 + s);
  endfunction

  function automatic logic [31:0] dw(int lp, int y, int mo, int d);
    return 32'(lp * 4194304 + y * 65536 + mo * 256 + d);
  endfunction

  // monitor: pops expected reads and compares away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_item_t it;
        it = sb_q[0];
        bus_addr = it.addr;
        #1;
        checks++;
        if (bus_rdata !== it.val) begin
          failures++;
          $display("FAIL %s addr=%0d actual=%08h expected=%08h",
                   it.tag, it.addr, bus_rdata, it.val);
        end
        void'(sb_q.pop_front());
      end
    end
  end

  task automatic expect_rd(logic [1:0] a, logic [31:0] v, string tag);
    exp_item_t it;
    it.addr = a;
    it.val  = v;
    it.tag  = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic bus_write(logic [1:0] a, logic [31:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic one_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_time(logic [31:0] v);
    bus_write(2'd1, v); one_tick(); one_tick();
  endtask

  task automatic set_date(logic [31:0] v);
    bus_write(2'd2, v); one_tick(); one_tick();
  endtask

  // date rolls at midnight from a given starting date
  task automatic midnight(logic [31:0] start, logic [31:0] expect_d, string tag);
    set_date(start);
    set_time(tw(23, 59, 59));
    one_tick();
    expect_rd(2'd2, expect_d, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    expect_rd(2'd0, 32'h0, "R1 ctrl");
    expect_rd(2'd1, 32'h0, "R1 time");
    expect_rd(2'd2, 32'h0000_0101, "R1 date");
    expect_rd(2'd3, 32'h0, "R2 addr3");

    // commit timing and ignored write while busy
    bus_write(2'd1, tw(23, 59, 58));
    expect_rd(2'd0, 32'h100, "R3 time busy");
    bus_write(2'd1, tw(0, 0, 1));
    one_tick();
    expect_rd(2'd0, 32'h100, "R4 busy after one tick");
    expect_rd(2'd1, tw(0, 0, 1), "R4 old count runs");
    one_tick();
    expect_rd(2'd0, 32'h0, "R4 busy cleared");
    expect_rd(2'd1, tw(23, 59, 58), "R5 first staged value kept");
    bus_write(2'd0, 32'hFFFF_FFFF);
    expect_rd(2'd0, 32'h0, "R5 ctrl write ignored");
    bus_write(2'd3, 32'hFFFF_FFFF);
    expect_rd(2'd1, tw(23, 59, 58), "R5 addr3 write ignored");

    one_tick();
    expect_rd(2'd1, tw(23, 59, 59), "R6 seconds count");
    one_tick();
    expect_rd(2'd1, 32'h0, "R7 midnight time");
    expect_rd(2'd2, dw(0, 0, 1, 2), "R7 day advance");

    set_time(tw(5, 10, 59));
    one_tick();
    expect_rd(2'd1, tw(5, 11, 0), "R6 minute carry");
    set_time(tw(5, 59, 59));
    one_tick();
    expect_rd(2'd1, tw(6, 0, 0), "R6 hour carry");

    // month lengths
    bus_write(2'd2, dw(1, 30, 2, 28));
    expect_rd(2'd0, 32'h80, "R3 date busy");
    one_tick(); one_tick();
    expect_rd(2'd2, dw(1, 30, 2, 28), "R4 date commit");
    set_time(tw(23, 59, 59));
    one_tick();
    expect_rd(2'd2, dw(1, 30, 2, 29), "R8 leap feb 29");
    set_time(tw(23, 59, 59));
    one_tick();
    expect_rd(2'd2, dw(1, 30, 3, 1), "R8 leap feb end");
    midnight(dw(0, 31, 2, 28), dw(0, 31, 3, 1), "R8 plain feb");
    midnight(dw(0, 31, 4, 30), dw(0, 31, 5, 1), "R8 april");
    midnight(dw(0, 31, 4, 29), dw(0, 31, 4, 30), "R8 april day 29");
    midnight(dw(0, 31, 1, 31), dw(0, 31, 2, 1), "R8 january");

    // year ends
    midnight(dw(0, 29, 12, 31), dw(1, 30, 1, 1), "R9 into leap year");
    midnight(dw(0, 63, 12, 31), dw(0, 0, 1, 1), "R9 offset wrap");

    // field masking
    set_date(32'hFFFF_FFFF);
    expect_rd(2'd2, 32'h007F_0F1F, "R10 date mask");
    set_date(dw(0, 3, 3, 3));
    set_time(32'hFFFF_FFFF);
    expect_rd(2'd1, 32'h001F_3F3F, "R10 time mask");

    // carry coinciding with date commit is dropped
    set_date(dw(0, 5, 6, 10));
    set_time(tw(23, 59, 58));
    bus_write(2'd2, dw(0, 5, 7, 4));
    one_tick();
    expect_rd(2'd2, dw(0, 5, 6, 10), "R11 date before commit");
    one_tick();
    expect_rd(2'd2, dw(0, 5, 7, 4), "R11 carry dropped");
    expect_rd(2'd1, 32'h0, "R11 time still rolls");

    // no tick, no change
    repeat (5) @(negedge clk);
    expect_rd(2'd1, 32'h0, "R12 time steady");
    expect_rd(2'd2, dw(0, 5, 7, 4), "R12 date steady");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule